// File: doc/BRIEF.md
# Page-Offset-Indexed, Physically-Tagged Lookup Cache

This block is a small direct-mapped data cache for a core that translates addresses. Each line holds one 32-bit word. The line index and the byte lane both come from bits of the virtual address that lie inside the 12-bit page offset. Those bits are the same before and after translation, so the cache can read its arrays while the translation unit is still resolving the page number. When the translation result arrives, it delivers a 20-bit physical page number and a hit flag. The block compares that page number with the tag stored in the indexed line and then decides hit or miss.

A lookup request is presented together with the translation result, and the answer appears one clock later. Refills from the next memory level write a line at the index taken from the virtual address. The tag written is the physical page number on the translation port in that cycle. The number of index bits is a parameter, with a default of 10, which gives 1K lines and 4 KB. Elaboration stops if the index bits plus the two byte-lane bits would reach past the page offset.

Top module: `vipt_cache`

## Requirements
- R1: Reset clears every line's valid flag, so the first lookup at any index after reset reports a miss. While reset is held, `rsp_valid` and `rsp_hit` are 0.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: A lookup hits only when the indexed line is valid, its stored tag equals `tlb_ppn`, and `tlb_hit` is high. A tag mismatch gives a miss. `rsp_hit` is never high without `rsp_valid`.
- R4: A lookup with `tlb_hit` low always reports a miss, even if the stored tag matches.
- R5: When `fill_en` is high at a clock edge, the line at index `req_vaddr[IDX_W+1:2]` takes `fill_data` as its data and `tlb_ppn` as its tag, and becomes valid. A later fill to the same index replaces the earlier tag.
- R6: A word read (`req_byte` = 0) returns the whole stored word on a hit, whatever the value of `req_vaddr[1:0]`.
- R7: A byte read (`req_byte` = 1) returns the byte in lane `req_vaddr[1:0]` in bits 7:0 of `rsp_data`, with the upper 24 bits zero. Lane 0 is bits 7:0 of the stored word and lane 3 is bits 31:24.
- R8: `rsp_data` is zero whenever `rsp_hit` is low.
- R9: Virtual address bits above the page offset affect neither the index nor the compare. Two virtual pages that map to the same physical page hit the same line.
- R10: A lookup and a fill at the same index in the same cycle see the line contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address for lookup and refill index |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| tlb_hit | input | 1 | Translation result is valid |
| tlb_ppn | input | 20 | Physical page number from translation |
| fill_en | input | 1 | Refill write strobe |
| fill_data | input | 32 | Refill data word |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 32 | Read data, zero on miss |

## Verification
The hardest situation to reach is the synonym case. Two different virtual pages carry identical offset bits and translate to the same physical page, so they must hit the same line. The bench produces it by filling through a low virtual page and then looking up through an address whose upper 20 bits are all ones, while presenting the same page number. A second hard case is a fill and a lookup landing on one index in the same edge. The bench produces it right after a reset by issuing both together, and then issues a plain lookup to show that the fill did land.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_OFS_W = 12;
    localparam int PPN_W      = VA_W - PAGE_OFS_W;
    localparam int WORD_W     = 32;
    localparam int BSEL_W     = 2;

    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BSEL_W-1:0] lane_t;

    typedef enum logic {
        RD_WORD = 1'b0,
        RD_BYTE = 1'b1
    } rd_size_e;

    typedef struct packed {
        logic valid;
        ppn_t tag;
    } tag_entry_t;

    function automatic word_t lane_extract(word_t w, lane_t sel);
        word_t r;
        r = '0;
        case (sel)
            2'd0: r[7:0] = w[7:0];
            2'd1: r[7:0] = w[15:8];
            2'd2: r[7:0] = w[23:16];
            default: r[7:0] = w[31:24];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output tag_entry_t       rd_entry,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ppn_t             wr_tag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    ppn_t             tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_comb begin
        rd_entry.valid = valid_q[rd_idx];
        rd_entry.tag   = tag_q[rd_idx];
    end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
    import vipt_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_word
);
    localparam int DEPTH = 1 << IDX_W;

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_word;
        end
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/vipt_lane_sel.sv
module vipt_lane_sel
    import vipt_pkg::*;
(
    input  word_t    word_in,
    input  lane_t    lane,
    input  rd_size_e size,
    output word_t    word_out
);
    always_comb begin
        if (size == RD_BYTE) begin
            word_out = lane_extract(word_in, lane);
        end else begin
            word_out = word_in;
        end
    end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_byte,
    input  logic        tlb_hit,
    input  logic [19:0] tlb_ppn,
    input  logic        fill_en,
    input  logic [31:0] fill_data,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_data
);
    localparam int IDX_LSB = BSEL_W;

    generate
        if (IDX_W < 1 || IDX_W + BSEL_W > PAGE_OFS_W) begin : g_bad_index
            $error("vipt_cache: index and lane bits must fit in the page offset");
        end
    endgenerate

    logic [IDX_W-1:0] idx;
    lane_t            lane;
    rd_size_e         size;
    tag_entry_t       entry;
    word_t            raw_word;
    word_t            sel_word;
    logic             hit_now;

    assign idx  = req_vaddr[IDX_LSB +: IDX_W];
    assign lane = req_vaddr[BSEL_W-1:0];
    assign size = rd_size_e'(req_byte);

    vipt_tag_store #(.IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_entry (entry),
        .wr_en    (fill_en),
        .wr_idx   (idx),
        .wr_tag   (tlb_ppn)
    );

    vipt_data_store #(.IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .rd_idx  (idx),
        .rd_word (raw_word),
        .wr_en   (fill_en),
        .wr_idx  (idx),
        .wr_word (fill_data)
    );

    vipt_lane_sel u_lane (
        .word_in  (raw_word),
        .lane     (lane),
        .size     (size),
        .word_out (sel_word)
    );

    assign hit_now = entry.valid && (entry.tag == tlb_ppn) && tlb_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && hit_now;
            rsp_data  <= (req_valid && hit_now) ? sel_word : '0;
        end
    end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int IDX_W = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_byte,
    input logic        tlb_hit,
    input logic [19:0] tlb_ppn,
    input logic        fill_en,
    input logic [31:0] fill_data,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_data
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_hit_implies_valid_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    assert_tlb_miss_forces_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tlb_hit) |=> !rsp_hit);

    assert_fill_then_hit_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !req_valid) ##1
        (req_valid && !fill_en && tlb_hit && !req_byte &&
         $stable(req_vaddr[IDX_W+1:2]) && $stable(tlb_ppn))
        |=> (rsp_hit && rsp_data == $past(fill_data, 2)));

    assert_miss_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_data == 32'h0));
endmodule

bind vipt_cache vipt_cache_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/vipt_cache_tb.sv
`timescale 1ns/1ps
module vipt_cache_tb;
    localparam int N = 14;

    localparam logic        T_FILL [N] = '{1,0,0,0,0,0,0,0,1,0,0,1,0,0};
    localparam logic [31:0] T_VA   [N] = '{
        32'h0000_1004, 32'h0000_1004, 32'h0000_1006, 32'h0000_1007,
        32'h0000_1004, 32'h0000_1004, 32'hFFFF_F004, 32'h0000_1008,
        32'h0000_2FFC, 32'h0000_2FFC, 32'h0000_2FFF, 32'h0000_1004,
        32'h0000_1004, 32'h0000_1004};
    localparam logic [19:0] T_PPN  [N] = '{
        20'h12345, 20'h12345, 20'h12345, 20'h12345,
        20'h12346, 20'h12345, 20'h12345, 20'h12345,
        20'h0ABCD, 20'h0ABCD, 20'h0ABCD, 20'h55555,
        20'h12345, 20'h55555};
    localparam logic        T_TLB  [N] = '{1,1,1,1,1,0,1,1,1,1,1,1,1,1};
    localparam logic        T_BYTE [N] = '{0,0,1,0,0,0,0,0,0,1,1,0,0,0};
    localparam logic [31:0] T_DATA [N] = '{
        32'hA1B2_C3D4, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h1122_3344, 32'h0, 32'h0, 32'hDEAD_BEEF, 32'h0, 32'h0};
    localparam logic        T_EHIT [N] = '{0,1,1,1,0,0,1,0,0,1,1,0,0,1};
    localparam logic [31:0] T_EDAT [N] = '{
        32'h0, 32'hA1B2_C3D4, 32'h0000_00B2, 32'hA1B2_C3D4,
        32'h0, 32'h0, 32'hA1B2_C3D4, 32'h0,
        32'h0, 32'h0000_0044, 32'h0000_0011, 32'h0,
        32'h0, 32'hDEAD_BEEF};

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_byte;
    logic        tlb_hit;
    logic [19:0] tlb_ppn;
    logic        fill_en;
    logic [31:0] fill_data;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    vipt_cache u_dut (.*);

    function automatic string tag_of(int i);
        case (i)
            0, 8, 11: return "R5";
            1:        return "R3";
            2, 9, 10: return "R7";
            3:        return "R6";
            4:        return "R3";
            5:        return "R4";
            6:        return "R9";
            7:        return "R5";
            12:       return "R5";
            default:  return "R3";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; fill_en = 1'b0; req_byte = 1'b0;
        tlb_hit = 1'b0; req_vaddr = '0; tlb_ppn = '0; fill_data = '0;
    endtask

    // called at a falling edge; drives one cycle and samples at the next falling edge
    task automatic apply(input logic fill, input logic req, input logic [31:0] va,
                         input logic [19:0] ppn, input logic th, input logic byt,
                         input logic [31:0] d);
        fill_en = fill; req_valid = req; req_vaddr = va; tlb_ppn = ppn;
        tlb_hit = th; req_byte = byt; fill_data = d;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        check("R1", "rsp_hit in reset", {31'b0, rsp_hit}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1: first lookup after reset misses
        apply(1'b0, 1'b1, 32'h0000_1004, 20'h12345, 1'b1, 1'b0, 32'h0);
        check("R1", "hit after reset", {31'b0, rsp_hit}, 32'h0);

        for (int i = 0; i < N; i++) begin
            apply(T_FILL[i], !T_FILL[i], T_VA[i], T_PPN[i], T_TLB[i], T_BYTE[i], T_DATA[i]);
            check("R2", $sformatf("rsp_valid step %0d", i), {31'b0, rsp_valid},
                  {31'b0, !T_FILL[i]});
            check(tag_of(i), $sformatf("rsp_hit step %0d", i), {31'b0, rsp_hit},
                  {31'b0, T_EHIT[i]});
            check(tag_of(i), $sformatf("rsp_data step %0d", i), rsp_data, T_EDAT[i]);
        end

        // R8: miss with a tag mismatch still yields zero data
        apply(1'b0, 1'b1, 32'h0000_2FFC, 20'h0ABCE, 1'b1, 1'b0, 32'h0);
        check("R8", "miss data", rsp_data, 32'h0);

        // R1: reset drops previously filled lines
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        apply(1'b0, 1'b1, 32'h0000_1004, 20'h55555, 1'b1, 1'b0, 32'h0);
        check("R1", "hit after second reset", {31'b0, rsp_hit}, 32'h0);

        // R10: fill and lookup together see the old (invalid) line
        apply(1'b1, 1'b1, 32'h0000_2FFC, 20'h0ABCD, 1'b1, 1'b0, 32'h0000_0099);
        check("R10", "same-cycle hit", {31'b0, rsp_hit}, 32'h0);
        check("R10", "same-cycle data", rsp_data, 32'h0);
        apply(1'b0, 1'b1, 32'h0000_2FFC, 20'h0ABCD, 1'b1, 1'b0, 32'h0);
        check("R10", "next-cycle data", rsp_data, 32'h0000_0099);

        // R2: idle cycle yields no response
        apply(1'b0, 1'b0, 32'h0, 20'h0, 1'b0, 1'b0, 32'h0);
        check("R2", "idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule